// File: doc/BRIEF.md
# Virtually Indexed Tag Directory with Alias Eviction

This block holds the tag and valid state of a 4-way set-associative L1 cache whose set is chosen from virtual address bits and whose tag is taken from physical address bits. Each request carries a virtual address and the physical address that an external translator produced for it. The block reports a hit with its way. On a miss it allocates a way and reports that way.

In the large (32 KB) geometry the top index bit lies above the 4 KB page offset, so one physical line can sit in either of two sets. On a miss in that geometry the block spends one extra cycle probing the sibling set. It invalidates any copy of the same physical line found there, and it announces the invalidated set and way so that an external data array can drop or write back that line. The probe can be switched off. In the small (16 KB) geometry the index stays inside the page offset and no probe is ever needed.

Top module: `vipt_dir`

## Requirements
- R1: While reset is asserted and after it is released, ready_o is 1, resp_valid_o and alias_evict_o are 0, and every line is invalid, so the first lookup of any address misses.
- R2: The set is req_va_i[12:6] when size32_i=1 and {0, req_va_i[11:6]} when size32_i=0. The stored tag is req_pa_i[31:12]. Address bits [5:0] have no effect on the result.
- R3: A request is accepted on a rising edge where ready_o=1 and req_valid_i=1. On a hit, resp_valid_o=1 and resp_hit_o=1 in the next cycle, and resp_way_o holds the matching way.
- R4: A miss that needs no probe gives resp_valid_o=1 and resp_hit_o=0 in the next cycle, with resp_way_o set to the allocated way. The line is installed, so a repeat of the request hits that way.
- R5: The victim is the lowest-numbered invalid way of the set. When all four ways are valid, the victim is the set's rotation pointer. The pointer starts at 0 and advances by one, modulo 4, after each such replacement.
- R6: With size32_i=1 and alias_en_i=1, a miss drops ready_o for exactly one cycle, and the response appears two cycles after acceptance.
- R7: During that probe, if the sibling set (index bit 6 inverted) holds a valid way with the same tag, that way is invalidated. In the same cycle as the response, alias_evict_o pulses for one cycle with alias_set_o and alias_way_o naming the way.
- R8: With alias_en_i=0 there is no probe and no eviction. A copy in the sibling set stays valid and still hits.
- R9: With size32_i=0 there is never a probe or an eviction, and every response comes one cycle after acceptance.
- R10: inval_all_i holds ready_o at 0 while it is high and clears every valid bit at the next edge. Later lookups miss.
- R11: A hit does not move the rotation pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| size32_i | input | 1 | 1 selects 128 sets (32 KB), 0 selects 64 sets (16 KB) |
| alias_en_i | input | 1 | enables the sibling-set probe |
| inval_all_i | input | 1 | clears all valid bits |
| req_valid_i | input | 1 | request present |
| req_va_i | input | 32 | virtual address |
| req_pa_i | input | 32 | translated physical address |
| ready_o | output | 1 | a request can be accepted |
| resp_valid_o | output | 1 | lookup result valid |
| resp_hit_o | output | 1 | 1 on hit, 0 on miss |
| resp_way_o | output | 2 | hit way or allocated way |
| alias_evict_o | output | 1 | one-cycle alias invalidation pulse |
| alias_set_o | output | 7 | set of the invalidated alias |
| alias_way_o | output | 2 | way of the invalidated alias |

## Verification
The assertions assume that size32_i and alias_en_i stay constant from the acceptance of a request until its response. They also assume that req_valid_i and the addresses are never unknown after reset. The bench changes both configuration inputs only between requests, once the previous response has been sampled. It drives every address as a defined value. It does not switch geometry in a way that puts a tag into a set that already holds it, so the assertion that at most one way matches stays meaningful.

// File: rtl/vipt_dir_pkg.sv
package vipt_dir_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned LINE_OFF  = 6;
  localparam int unsigned IDX_W     = 7;
  localparam int unsigned WAYS      = 4;
  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned SETS      = 1 << IDX_W;
  localparam int unsigned WAY_W     = $clog2(WAYS);
  localparam int unsigned TAG_W     = ADDR_W - PAGE_BITS;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [TAG_W-1:0] tag_t;
  typedef logic [WAY_W-1:0] way_t;
  typedef enum logic {ST_IDLE, ST_PROBE} st_e;
endpackage

// File: rtl/vipt_tag_match.sv
module vipt_tag_match
  import vipt_dir_pkg::*;
(
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  tag_t                       tag_i,
  output logic                       hit_o,
  output logic [WAYS-1:0]            hit_vec_o,
  output way_t                       way_o
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec_o[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec_o[w]) way_o = way_t'(w);
    end
  end
endmodule

// File: rtl/vipt_victim_sel.sv
module vipt_victim_sel
  import vipt_dir_pkg::*;
(
  input  logic [WAYS-1:0] valid_i,
  input  way_t            rr_i,
  output way_t            way_o,
  output logic            use_rr_o
);
  assign use_rr_o = &valid_i;

  // lowest invalid way wins
  always_comb begin
    way_o = rr_i;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) way_o = way_t'(w);
    end
  end
endmodule

// File: rtl/vipt_dir.sv
module vipt_dir
  import vipt_dir_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              size32_i,
  input  logic              alias_en_i,
  input  logic              inval_all_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_va_i,
  input  logic [ADDR_W-1:0] req_pa_i,
  output logic              ready_o,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [WAY_W-1:0]  resp_way_o,
  output logic              alias_evict_o,
  output logic [IDX_W-1:0]  alias_set_o,
  output logic [WAY_W-1:0]  alias_way_o
);
  localparam idx_t ALIAS_BIT = idx_t'(1) << (IDX_W - 1);

  st_e  st_q;
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  way_t rr_q [SETS];
  idx_t cap_set_q;
  tag_t cap_tag_q;

  idx_t req_set, lk_set, alt_set;
  tag_t req_tag, lk_tag;
  logic accept, probe_mode, do_alloc, do_evict;
  logic prim_hit, alt_hit, use_rr;
  logic [WAYS-1:0] prim_hit_vec, alt_hit_vec;
  way_t prim_way, alt_way, vict_way;

  logic unused_bits;
  assign unused_bits = ^{req_va_i[ADDR_W-1:LINE_OFF+IDX_W], req_va_i[LINE_OFF-1:0]};

  always_comb begin
    req_set = req_va_i[LINE_OFF +: IDX_W];
    if (!size32_i) req_set[IDX_W-1] = 1'b0;
  end
  assign req_tag    = req_pa_i[ADDR_W-1:PAGE_BITS];
  assign ready_o    = (st_q == ST_IDLE) && !inval_all_i;
  assign accept     = ready_o && req_valid_i;
  assign probe_mode = size32_i && alias_en_i;

  assign lk_set  = (st_q == ST_PROBE) ? cap_set_q : req_set;
  assign lk_tag  = (st_q == ST_PROBE) ? cap_tag_q : req_tag;
  assign alt_set = cap_set_q ^ ALIAS_BIT;

  vipt_tag_match u_prim (
    .valid_i(valid_q[lk_set]), .tags_i(tag_q[lk_set]), .tag_i(lk_tag),
    .hit_o(prim_hit), .hit_vec_o(prim_hit_vec), .way_o(prim_way)
  );

  vipt_tag_match u_alt (
    .valid_i(valid_q[alt_set]), .tags_i(tag_q[alt_set]), .tag_i(cap_tag_q),
    .hit_o(alt_hit), .hit_vec_o(alt_hit_vec), .way_o(alt_way)
  );

  vipt_victim_sel u_vict (
    .valid_i(valid_q[lk_set]), .rr_i(rr_q[lk_set]),
    .way_o(vict_way), .use_rr_o(use_rr)
  );

  assign do_alloc = (accept && !prim_hit && !probe_mode) || (st_q == ST_PROBE);
  assign do_evict = (st_q == ST_PROBE) && alt_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      cap_set_q     <= '0;
      cap_tag_q     <= '0;
      resp_valid_o  <= 1'b0;
      resp_hit_o    <= 1'b0;
      resp_way_o    <= '0;
      alias_evict_o <= 1'b0;
      alias_set_o   <= '0;
      alias_way_o   <= '0;
    end else begin
      if (st_q == ST_PROBE)                      st_q <= ST_IDLE;
      else if (accept && !prim_hit && probe_mode) st_q <= ST_PROBE;
      if (accept) begin
        cap_set_q <= req_set;
        cap_tag_q <= req_tag;
      end
      resp_valid_o  <= (accept && (prim_hit || !probe_mode)) || (st_q == ST_PROBE);
      resp_hit_o    <= accept && prim_hit;
      resp_way_o    <= (accept && prim_hit) ? prim_way : vict_way;
      alias_evict_o <= do_evict;
      if (do_evict) begin
        alias_set_o <= alt_set;
        alias_way_o <= alt_way;
      end
    end
  end

  // valid bits and rotation pointers; flush wins over any update
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (inval_all_i) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else begin
      if (do_alloc) begin
        valid_q[lk_set][vict_way] <= 1'b1;
        if (use_rr) rr_q[lk_set] <= way_t'(rr_q[lk_set] + 1'b1);
      end
      if (do_evict) valid_q[alt_set][alt_way] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_alloc && !inval_all_i) tag_q[lk_set][vict_way] <= lk_tag;
  end
endmodule

// File: rtl/vipt_dir_chk.sv
module vipt_dir_chk
  import vipt_dir_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            inval_all_i,
  input logic            ready_o,
  input logic            resp_valid_o,
  input logic            resp_hit_o,
  input logic            alias_evict_o,
  input logic [WAYS-1:0] prim_hit_vec,
  input logic [WAYS-1:0] valid_q [SETS]
);
  logic any_valid;
  always_comb begin
    any_valid = 1'b0;
    for (int s = 0; s < SETS; s++) any_valid = any_valid | (|valid_q[s]);
  end

  p_unique_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(prim_hit_vec));

  p_probe_one_cycle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !inval_all_i) |=> (ready_o || inval_all_i));

  p_evict_after_probe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_evict_o |-> !$past(ready_o));

  p_evict_on_miss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alias_evict_o |-> (resp_valid_o && !resp_hit_o));

  p_flush_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inval_all_i) |-> !any_valid);
endmodule

bind vipt_dir vipt_dir_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .inval_all_i(inval_all_i), .ready_o(ready_o),
  .resp_valid_o(resp_valid_o), .resp_hit_o(resp_hit_o), .alias_evict_o(alias_evict_o),
  .prim_hit_vec(prim_hit_vec), .valid_q(valid_q)
);

// File: tb/vipt_dir_tb.sv
module vipt_dir_tb;
  logic clk_i = 1'b0;
  logic rst_ni, size32_i, alias_en_i, inval_all_i, req_valid_i;
  logic [31:0] req_va_i, req_pa_i;
  logic ready_o, resp_valid_o, resp_hit_o, alias_evict_o;
  logic [1:0] resp_way_o, alias_way_o;
  logic [6:0] alias_set_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  vipt_dir u_dut (.*);

  typedef struct packed {
    logic sz; logic ae; logic [31:0] va; logic [31:0] pa;
    logic hit; logic [1:0] way; logic probe; logic ev; logic [6:0] eset; logic [1:0] eway;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b1,32'h0000_0140,32'h1111_1140,1'b0,2'd0,1'b1,1'b0,7'd0 ,2'd0}, // R6 first miss
    '{1'b1,1'b1,32'h0000_0140,32'h1111_1140,1'b1,2'd0,1'b0,1'b0,7'd0 ,2'd0}, // R3 hit
    '{1'b1,1'b1,32'h0000_1140,32'h1111_1140,1'b0,2'd0,1'b1,1'b1,7'd5 ,2'd0}, // R7 alias in set 5
    '{1'b1,1'b1,32'h0000_0140,32'h1111_1140,1'b0,2'd0,1'b1,1'b1,7'd69,2'd0}, // R7 alias back
    '{1'b1,1'b1,32'h0000_0140,32'h2222_2140,1'b0,2'd1,1'b1,1'b0,7'd0 ,2'd0}, // R5 fill
    '{1'b1,1'b1,32'h0000_0140,32'h3333_3140,1'b0,2'd2,1'b1,1'b0,7'd0 ,2'd0},
    '{1'b1,1'b1,32'h0000_0140,32'h4444_4140,1'b0,2'd3,1'b1,1'b0,7'd0 ,2'd0},
    '{1'b1,1'b1,32'h0000_0140,32'h5555_5140,1'b0,2'd0,1'b1,1'b0,7'd0 ,2'd0}, // R5 rotate 0
    '{1'b1,1'b1,32'h0000_0140,32'h6666_6140,1'b0,2'd1,1'b1,1'b0,7'd0 ,2'd0}, // R5 rotate 1
    '{1'b1,1'b1,32'h0000_0140,32'h3333_3140,1'b1,2'd2,1'b0,1'b0,7'd0 ,2'd0}, // R11 hit
    '{1'b1,1'b1,32'h0000_0140,32'h7777_7140,1'b0,2'd2,1'b1,1'b0,7'd0 ,2'd0}, // R11 rotate 2
    '{1'b1,1'b0,32'h0000_1140,32'h5555_5140,1'b0,2'd0,1'b0,1'b0,7'd0 ,2'd0}, // R8 no probe
    '{1'b1,1'b0,32'h0000_0140,32'h5555_5140,1'b1,2'd0,1'b0,1'b0,7'd0 ,2'd0}, // R8 copy kept
    '{1'b1,1'b0,32'h0000_1140,32'h5555_5140,1'b1,2'd0,1'b0,1'b0,7'd0 ,2'd0}, // R8
    '{1'b0,1'b1,32'h0000_0140,32'h8888_8140,1'b0,2'd3,1'b0,1'b0,7'd0 ,2'd0}, // R9 rotate 3
    '{1'b0,1'b1,32'h0000_1140,32'h8888_8140,1'b1,2'd3,1'b0,1'b0,7'd0 ,2'd0}, // R2 va12 ignored
    '{1'b0,1'b1,32'h0000_1140,32'h9999_9140,1'b0,2'd0,1'b0,1'b0,7'd0 ,2'd0}, // R9 wraps to 0
    '{1'b1,1'b1,32'h0000_017F,32'h9999_917F,1'b1,2'd0,1'b0,1'b0,7'd0 ,2'd0}, // R2 offset ignored
    '{1'b1,1'b1,32'h0000_0FC0,32'h1234_5FC0,1'b0,2'd0,1'b1,1'b0,7'd0 ,2'd0}  // R6 set 63
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run(vec_t v, string req);
    @(negedge clk_i);
    chk("R7", {req, " prior pulse gone"}, {31'd0, alias_evict_o}, 32'd0);
    size32_i = v.sz; alias_en_i = v.ae; req_va_i = v.va; req_pa_i = v.pa;
    req_valid_i = 1'b1;
    chk("R3", {req, " ready"}, {31'd0, ready_o}, 32'd1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (v.probe) begin
      chk("R6", {req, " ready in probe"}, {31'd0, ready_o}, 32'd0);
      chk("R6", {req, " resp early"}, {31'd0, resp_valid_o}, 32'd0);
      @(negedge clk_i);
    end
    chk(req, "resp_valid", {31'd0, resp_valid_o}, 32'd1);
    chk(req, "hit", {31'd0, resp_hit_o}, {31'd0, v.hit});
    chk(req, "way", {30'd0, resp_way_o}, {30'd0, v.way});
    chk(req, "evict", {31'd0, alias_evict_o}, {31'd0, v.ev});
    if (v.ev) begin
      chk("R7", {req, " alias set"}, {25'd0, alias_set_o}, {25'd0, v.eset});
      chk("R7", {req, " alias way"}, {30'd0, alias_way_o}, {30'd0, v.eway});
    end
  endtask

  initial begin
    rst_ni = 1'b0; size32_i = 1'b1; alias_en_i = 1'b1; inval_all_i = 1'b0;
    req_valid_i = 1'b0; req_va_i = '0; req_pa_i = '0;
    repeat (3) @(negedge clk_i);
    chk("R1", "ready in reset", {31'd0, ready_o}, 32'd1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "resp_valid idle", {31'd0, resp_valid_o}, 32'd0);
    chk("R1", "evict idle", {31'd0, alias_evict_o}, 32'd0);

    for (int i = 0; i < NV; i++) run(VEC[i], $sformatf("vec%0d", i));

    // R1 reset mid-run clears state
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    run('{1'b1,1'b1,32'h140,32'h9999_9140,1'b0,2'd0,1'b1,1'b0,7'd0,2'd0}, "R1 after reset");
    run('{1'b1,1'b1,32'h140,32'h9999_9140,1'b1,2'd0,1'b0,1'b0,7'd0,2'd0}, "R4 installed");

    // R10 flush
    @(negedge clk_i); inval_all_i = 1'b1;
    #1 chk("R10", "ready during flush", {31'd0, ready_o}, 32'd0);
    @(negedge clk_i); inval_all_i = 1'b0;
    run('{1'b1,1'b0,32'h140,32'h9999_9140,1'b0,2'd0,1'b0,1'b0,7'd0,2'd0}, "R10 after flush");
    run('{1'b1,1'b0,32'h0FC0,32'h1234_5FC0,1'b0,2'd0,1'b0,1'b0,7'd0,2'd0}, "R10 other set");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule